// File: doc/BRIEF.md
# Dual-Clock Watchdog with Synchronized Configuration

This block is a watchdog timer whose counter lives on a slow, free-running clock. Its configuration word and its feed command come from a fast bus clock. The bus side offers three things: a configuration write, a feed strobe and two busy indications. Each bus action travels into the slow domain through its own toggle handshake. The busy flag for that path stays high until the slow side acknowledges the action. Once enabled, the slow counter must be fed before its selected period runs out. If it is not, the block emits a single-cycle reset request in the slow domain and starts counting again from zero.

Configuration word layout (13 bits): bit 0 enable, bit 1 keep-running-in-debug, bits 2 and 3 keep-running in two sleep levels, bits 4 and 5 inhibit disabling of two clock sources, bits 7:6 clock source select, bits 11:8 period code, bit 12 lock. Only enable, the period code and lock act inside this block. The remaining fields are stored and carried across to the slow side for neighbouring logic.

The bus-side controller is a state machine with four states. CFG_OPEN accepts writes. CFG_XFER and CFG_LOCK_XFER wait for a transfer, the second of them for a transfer that carries the lock bit. CFG_LOCKED is the terminal state. An accepted write moves CFG_OPEN to CFG_XFER, or to CFG_LOCK_XFER when bit 12 is set. CFG_XFER returns to CFG_OPEN when the busy flag drops. CFG_LOCK_XFER moves to CFG_LOCKED when the busy flag drops. CFG_LOCKED is left only by reset. The slow counter is a second state machine with three states. CNT_OFF holds the count at zero. CNT_RUN counts. CNT_FIRE lasts one cycle and raises the reset request. CNT_OFF goes to CNT_RUN on enable. CNT_RUN goes to CNT_OFF on disable, and to CNT_FIRE when the count reaches its terminal value. CNT_FIRE goes back to CNT_RUN, or to CNT_OFF if the block is disabled.

Top module: `wdx_watchdog`

## Requirements
- R1: After reset, both busy flags, the reset request, the count, the read-back word and the applied slow-side word are all zero.
- R2: A configuration write in the open state is accepted in the same cycle (ctrl_accept high). The read-back word holds the new value and ctrl_busy is high from the next bus cycle.
- R3: ctrl_busy falls only after the slow side has taken the word. When it falls, cfg_applied equals the written value, and this happens within 40 bus cycles at a 4:1 clock ratio.
- R4: A configuration write while ctrl_busy is high is refused (ctrl_accept low) and leaves the read-back word unchanged.
- R5: Bits 1 to 7 of the word are stored unchanged and carried to cfg_applied along with enable and the period code.
- R6: When enabled with period code p and not fed, wd_reset_req pulses for exactly one slow cycle. Consecutive pulses are 2^(p+3)+2 slow cycles apart: one fire cycle, then 2^(p+3)+1 counting cycles. The count restarts from zero after each pulse.
- R7: A feed while enabled raises cmd_busy and returns the count to zero. Feeds issued well inside the period prevent any reset request.
- R8: A feed while the read-back enable bit is zero is ignored: cmd_busy stays low.
- R9: A feed while cmd_busy is high is merged into the pending one. cmd_busy stays high and falls within the bound of a single transfer.
- R10: A write with bit 12 set locks the configuration. Every later write is refused, including one that clears enable, and reset pulses continue. Only reset unlocks.
- R11: The lock bit can be set while enable is zero. The block then stays disabled and refuses any write that would enable it.
- R12: While disabled the count is zero and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| slow_clk | input | 1 | Slow counter clock |
| slow_rst_n | input | 1 | Asynchronous active-low reset, slow domain |
| ctrl_wr | input | 1 | Configuration write strobe |
| ctrl_wdata | input | 13 | Configuration word to write |
| ctrl_accept | output | 1 | Write taken this cycle |
| ctrl_rdata | output | 13 | Bus-side copy of the last accepted word |
| ctrl_busy | output | 1 | Configuration transfer in flight |
| feed | input | 1 | Feed (counter clear) strobe |
| cmd_busy | output | 1 | Feed transfer in flight |
| cfg_applied | output | 13 | Word in effect in the slow domain |
| wd_count | output | 19 | Slow-domain counter value |
| wd_reset_req | output | 1 | One-slow-cycle reset request |

## Verification
ctrl_accept is combinational and is sampled one time unit after the write is driven. ctrl_rdata and ctrl_busy change at the next bus edge and are sampled at the following falling edge. Transfer completion takes three slow edges plus two bus edges. The bench does not count these cycles exactly. It polls the busy flag at each falling bus edge against a 40-cycle bound, and only then compares cfg_applied or the count. Reset-request timing is measured purely in the slow domain: a monitor samples each falling slow edge and records the spacing between pulses and whether any pulse lasts two samples. Checks are made only after the second pulse that follows a configuration change, so the leftover count from the old setting cannot skew the result.

// File: rtl/wdx_pkg.sv
package wdx_pkg;
    localparam int EN_POS   = 0;
    localparam int PER_LO   = 8;
    localparam int PER_W    = 4;
    localparam int LOCK_POS = 12;
    localparam int CFG_W    = 13;
    localparam int PER_BIAS = 3;
    // widest terminal value is 2^(2^PER_W - 1 + PER_BIAS)
    localparam int CNT_W    = (1 << PER_W) + PER_BIAS;

    typedef enum logic [1:0] {
        CFG_OPEN,
        CFG_XFER,
        CFG_LOCK_XFER,
        CFG_LOCKED
    } cfg_state_e;

    typedef enum logic [1:0] {
        CNT_OFF,
        CNT_RUN,
        CNT_FIRE
    } cnt_state_e;
endpackage

// File: rtl/wdx_toggle_xfer.sv
module wdx_toggle_xfer #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic start,
    output logic busy,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic              req_t;
    logic [STAGES-1:0] ack_sync;
    logic [STAGES-1:0] req_sync;
    logic              req_seen;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            req_t    <= 1'b0;
            ack_sync <= '0;
        end else begin
            if (start) req_t <= ~req_t;
            ack_sync <= {ack_sync[STAGES-2:0], req_seen};
        end
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            req_sync <= '0;
            req_seen <= 1'b0;
        end else begin
            req_sync <= {req_sync[STAGES-2:0], req_t};
            req_seen <= req_sync[STAGES-1];
        end
    end

    assign dst_pulse = req_sync[STAGES-1] ^ req_seen;
    assign busy      = req_t ^ ack_sync[STAGES-1];

    // R9: a new transfer is launched only when the path is idle
    p_start_idle_r9: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        start |-> !busy);
    // R3: busy rises only because a transfer was launched
    p_busy_cause_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $rose(busy) |-> $past(start));
    // R9: one launch gives one destination pulse
    p_pulse_single_r9: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |=> !dst_pulse);
endmodule

// File: rtl/wdx_bus_ctl.sv
module wdx_bus_ctl
    import wdx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [CFG_W-1:0] ctrl_wdata,
    input  logic             feed,
    input  logic             ctrl_busy,
    input  logic             cmd_busy,
    output logic             ctrl_accept,
    output logic             ctrl_start,
    output logic             cmd_start,
    output logic [CFG_W-1:0] shadow
);
    cfg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_OPEN:
                if (ctrl_wr) state_d = ctrl_wdata[LOCK_POS] ? CFG_LOCK_XFER : CFG_XFER;
            CFG_XFER:
                if (!ctrl_busy) state_d = CFG_OPEN;
            CFG_LOCK_XFER:
                if (!ctrl_busy) state_d = CFG_LOCKED;
            CFG_LOCKED:
                state_d = CFG_LOCKED;
            default:
                state_d = CFG_OPEN;
        endcase
    end

    always_comb begin
        ctrl_accept = 1'b0;
        unique case (state_q)
            CFG_OPEN:      ctrl_accept = ctrl_wr;
            CFG_XFER,
            CFG_LOCK_XFER,
            CFG_LOCKED:    ctrl_accept = 1'b0;
            default:       ctrl_accept = 1'b0;
        endcase
        ctrl_start = ctrl_accept;
        cmd_start  = feed && shadow[EN_POS] && !cmd_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           shadow <= '0;
        else if (ctrl_accept) shadow <= ctrl_wdata;
    end

    // R4: no write is taken while a configuration transfer is in flight
    p_accept_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_accept |-> !ctrl_busy);
    // R10: the locked state is left only by reset
    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_LOCKED) |=> (state_q == CFG_LOCKED));
    // R10: the shadow word is frozen once locked
    p_lock_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_LOCKED) |=> $stable(shadow));
    // R8: a feed is never launched while disabled
    p_feed_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shadow[EN_POS] |-> !cmd_start);
endmodule

// File: rtl/wdx_slow_cnt.sv
module wdx_slow_cnt
    import wdx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] load_data,
    input  logic             clear,
    output logic [CFG_W-1:0] cfg_q,
    output logic [CNT_W-1:0] count,
    output logic             fire
);
    cnt_state_e       state_q, state_d;
    logic             en;
    logic [PER_W-1:0] per;
    logic [CNT_W-1:0] top_val;
    logic             at_top;

    assign en      = cfg_q[EN_POS];
    assign per     = cfg_q[PER_LO +: PER_W];
    assign top_val = CNT_W'(1) << (int'(per) + PER_BIAS);
    assign at_top  = (count >= top_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cfg_q <= '0;
        else if (load) cfg_q <= load_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_OFF:  if (en) state_d = CNT_RUN;
            CNT_RUN: begin
                if (!en)                 state_d = CNT_OFF;
                else if (!clear && at_top) state_d = CNT_FIRE;
            end
            CNT_FIRE: state_d = en ? CNT_RUN : CNT_OFF;
            default:  state_d = CNT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (state_q)
                CNT_RUN:  count <= (!en || clear || at_top) ? '0 : count + 1'b1;
                CNT_OFF,
                CNT_FIRE: count <= '0;
                default:  count <= '0;
            endcase
        end
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            CNT_FIRE:         fire = 1'b1;
            CNT_OFF, CNT_RUN: fire = 1'b0;
            default:          fire = 1'b0;
        endcase
    end

    // R6: the request is a single-cycle pulse
    p_fire_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    // R6: after a pulse the count starts over from zero
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (count == '0));
    // R12: an idle counter reads zero
    p_off_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_OFF) |-> (count == '0));
    // R12: a pulse needs the enable bit set in the previous cycle
    p_fire_needs_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(en));
    // R7: a feed seen while counting empties the count
    p_feed_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && clear) |=> (count == '0));
endmodule

// File: rtl/wdx_watchdog.sv
module wdx_watchdog
    import wdx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             slow_clk,
    input  logic             slow_rst_n,
    input  logic             ctrl_wr,
    input  logic [CFG_W-1:0] ctrl_wdata,
    output logic             ctrl_accept,
    output logic [CFG_W-1:0] ctrl_rdata,
    output logic             ctrl_busy,
    input  logic             feed,
    output logic             cmd_busy,
    output logic [CFG_W-1:0] cfg_applied,
    output logic [CNT_W-1:0] wd_count,
    output logic             wd_reset_req
);
    logic ctrl_start, cmd_start;
    logic ctrl_pulse, cmd_pulse;

    wdx_bus_ctl u_bus (
        .clk         (bus_clk),
        .rst_n       (bus_rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (ctrl_wdata),
        .feed        (feed),
        .ctrl_busy   (ctrl_busy),
        .cmd_busy    (cmd_busy),
        .ctrl_accept (ctrl_accept),
        .ctrl_start  (ctrl_start),
        .cmd_start   (cmd_start),
        .shadow      (ctrl_rdata)
    );

    wdx_toggle_xfer #(.STAGES(SYNC_STAGES)) u_ctrl_xfer (
        .src_clk   (bus_clk),
        .src_rst_n (bus_rst_n),
        .start     (ctrl_start),
        .busy      (ctrl_busy),
        .dst_clk   (slow_clk),
        .dst_rst_n (slow_rst_n),
        .dst_pulse (ctrl_pulse)
    );

    wdx_toggle_xfer #(.STAGES(SYNC_STAGES)) u_cmd_xfer (
        .src_clk   (bus_clk),
        .src_rst_n (bus_rst_n),
        .start     (cmd_start),
        .busy      (cmd_busy),
        .dst_clk   (slow_clk),
        .dst_rst_n (slow_rst_n),
        .dst_pulse (cmd_pulse)
    );

    wdx_slow_cnt u_cnt (
        .clk       (slow_clk),
        .rst_n     (slow_rst_n),
        .load      (ctrl_pulse),
        .load_data (ctrl_rdata),
        .clear     (cmd_pulse),
        .cfg_q     (cfg_applied),
        .count     (wd_count),
        .fire      (wd_reset_req)
    );
endmodule

// File: tb/test_wdx_watchdog.sv
module test_wdx_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int SLOW_RATIO = 4;
    localparam int BUSY_LIMIT = 40;

    logic        bus_clk = 0, slow_clk = 0;
    logic        bus_rst_n = 0, slow_rst_n = 0;
    logic        ctrl_wr = 0, feed = 0;
    logic [12:0] ctrl_wdata = '0;
    logic        ctrl_accept, ctrl_busy, cmd_busy, wd_reset_req;
    logic [12:0] ctrl_rdata, cfg_applied;
    logic [18:0] wd_count;

    int checks = 0, fails = 0, cyc = 0;
    int pulse_cnt = 0, gap_ctr = 0, last_gap = 0;
    bit wide = 0, prev_req = 0;

    always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
    always #(CLK_PERIOD*SLOW_RATIO/2) slow_clk = ~slow_clk;

    wdx_watchdog i_wdx_watchdog (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_accept(ctrl_accept),
        .ctrl_rdata(ctrl_rdata), .ctrl_busy(ctrl_busy), .feed(feed), .cmd_busy(cmd_busy),
        .cfg_applied(cfg_applied), .wd_count(wd_count), .wd_reset_req(wd_reset_req)
    );

    always @(negedge slow_clk) begin
        if (slow_rst_n) begin
            if (wd_reset_req) begin
                if (prev_req) wide = 1;
                last_gap  = gap_ctr;
                gap_ctr   = 1;
                pulse_cnt = pulse_cnt + 1;
            end else begin
                gap_ctr = gap_ctr + 1;
            end
            prev_req = wd_reset_req;
        end
    end

    function automatic int exp_gap(input int code);
        return (1 << (code + 3)) + 2;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge bus_clk);
        bus_rst_n = 0; slow_rst_n = 0;
        repeat (10) @(negedge bus_clk);
        bus_rst_n = 1; slow_rst_n = 1;
        repeat (2) @(negedge bus_clk);
    endtask

    task automatic do_write(input logic [12:0] v, output bit acc);
        @(negedge bus_clk);
        ctrl_wr = 1; ctrl_wdata = v;
        #1 acc = ctrl_accept;
        @(negedge bus_clk);
        ctrl_wr = 0;
    endtask

    task automatic wait_ctrl(output int n);
        n = 0;
        while (ctrl_busy && n < 200) begin @(negedge bus_clk); n++; end
    endtask

    task automatic wait_cmd(output int n);
        n = 0;
        while (cmd_busy && n < 200) begin @(negedge bus_clk); n++; end
    endtask

    task automatic do_feed();
        @(negedge bus_clk); feed = 1;
        @(negedge bus_clk); feed = 0;
    endtask

    task automatic wait_pulses(input int n);
        int target = pulse_cnt + n;
        for (int k = 0; k < 3000 && pulse_cnt < target; k++) @(negedge bus_clk);
    endtask

    always @(posedge bus_clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        bit acc;
        int n, p0;
        logic [12:0] v;
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        check("R1 ctrl_busy", ctrl_busy, 0);
        check("R1 cmd_busy", cmd_busy, 0);
        check("R1 req", wd_reset_req, 0);
        check("R1 count", wd_count, 0);
        check("R1 rdata", ctrl_rdata, 0);
        check("R1 applied", cfg_applied, 0);

        // R8 feed while disabled is ignored; R12 disabled stays quiet
        do_feed();
        check("R8 cmd_busy", cmd_busy, 0);
        repeat (40) @(negedge bus_clk);
        check("R12 count", wd_count, 0);
        check("R12 pulses", pulse_cnt, 0);

        // R2, R4, R3: write, busy write refused, transfer completes
        do_write(13'h001, acc);
        check("R2 accept", acc, 1);
        check("R2 busy", ctrl_busy, 1);
        check("R2 rdata", ctrl_rdata, 13'h001);
        do_write(13'h0FE, acc);
        check("R4 refused", acc, 0);
        check("R4 rdata", ctrl_rdata, 13'h001);
        wait_ctrl(n);
        check("R3 bound", n <= BUSY_LIMIT, 1);
        check("R3 applied", cfg_applied, 13'h001);

        // R6 timeout period for code 0
        wait_pulses(3);
        check("R6 gap", last_gap, exp_gap(0));
        check("R6 width", wide, 0);

        // R7, R9 feeding keeps it quiet; merged feeds
        do_write(13'h201, acc);
        wait_ctrl(n);
        do_feed();
        check("R7 cmd_busy", cmd_busy, 1);
        wait_cmd(n);
        check("R7 count cleared", wd_count <= 2, 1);
        p0 = pulse_cnt;
        for (int i = 0; i < 15; i++) begin
            do_feed();
            do_feed();
            check("R9 merged busy", cmd_busy, 1);
            wait_cmd(n);
            check("R9 bound", n <= BUSY_LIMIT, 1);
            repeat (20) @(negedge bus_clk);
        end
        check("R7 no pulse", pulse_cnt, p0);

        // R5, R6 random configurations
        for (int i = 0; i < 6; i++) begin
            int c = $urandom % 3;
            v = 13'(1 | (c << 8) | (($urandom % 128) << 1));
            do_write(v, acc);
            check("R2 accept rnd", acc, 1);
            wait_ctrl(n);
            check("R5 applied", cfg_applied, v);
            check("R5 rdata", ctrl_rdata, v);
            wait_pulses(2);
            check("R6 gap rnd", last_gap, exp_gap(c));
        end
        check("R6 width rnd", wide, 0);

        // R10 lock while enabled
        do_write(13'h1001, acc);
        check("R10 lock accept", acc, 1);
        wait_ctrl(n);
        do_write(13'h0000, acc);
        check("R10 refused", acc, 0);
        check("R10 rdata", ctrl_rdata, 13'h1001);
        wait_pulses(2);
        check("R10 still firing", last_gap, exp_gap(0));

        // R10 reset unlocks; R11 lock while disabled
        do_reset();
        check("R10 unlocked", ctrl_rdata, 0);
        do_write(13'h1000, acc);
        check("R11 lock accept", acc, 1);
        wait_ctrl(n);
        do_write(13'h0001, acc);
        check("R11 enable refused", acc, 0);
        p0 = pulse_cnt;
        repeat (120) @(negedge bus_clk);
        check("R11 no pulse", pulse_cnt, p0);
        check("R12 count off", wd_count, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule